// File: doc/BRIEF.md
# DDR2 Posted-Read Burst Scheduler

This block sits between a memory controller's read queue and the command bus of a DDR2 device. A request names a bank and a column and carries a tag. The block checks the request against a vector of open-bank flags. If the bank is open, it drives a posted-CAS READ on the command bus for one cycle. If the bank is closed, it raises an error pulse instead. Every cycle that carries no READ drives NOP.

For every READ it issues, the block works out the exact clock window in which data will come back. That window opens after a read latency equal to the additive latency plus the CAS latency, and it lasts half a burst length in clocks, because each clock carries two beats. A shift pipeline carries a valid bit, the request tag and a beat-pair counter down to the output, so on every clock the controller knows whether data is due, which burst it belongs to and which pair of beats it is.

Requests are held off until half a burst length has passed since the last READ. A stream of requests therefore lands exactly one burst apart and fills the data bus with no gap, whether the reads go to one bank or to several.

Top module: `ddr2_rd_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, cmd_code is NOP (3'b111), dv_valid and rd_err are low and req_ready is high.
- R2: A request accepted at a clock edge (req_valid and req_ready both high) to a bank whose bank_open bit is set drives cmd_code to READ (3'b101), with cmd_bank and cmd_col equal to the request, for exactly the one cycle after that edge. Every other cycle shows NOP.
- R3: An accepted request to a bank whose bank_open bit is clear raises rd_err for the one cycle after acceptance. It issues no READ, creates no data window and does not restart the spacing, so req_ready stays high.
- R4: dv_valid first goes high RL = AL + CL cycles after the cycle in which the READ appears on cmd_code.
- R5: Each READ produces BL/2 consecutive dv_valid cycles. In them, dv_pair counts 0, 1, ... BL/2-1 (pair k carries beats 2k and 2k+1), and dv_tag equals the request tag.
- R6: After an issued READ, req_ready is low for BL/2-1 cycles and then high again, so the next READ is at least BL/2 cycles later.
- R7: When READs are issued exactly BL/2 cycles apart, dv_valid stays high across the burst boundary, dv_pair wraps from BL/2-1 to 0, and dv_tag switches to the new tag in the same cycle.
- R8: AL (cfg_al, 0 to 4), CL (cfg_cl, 3 to 5) and BL (cfg_bl8 high gives 8, low gives 4) are taken at acceptance. They may change only while no read is outstanding, and a change applies to the next request.
- R9: Back-to-back READs to the same open bank and to different open banks both stream under R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_al | input | 3 | Additive latency, 0 to 4 |
| cfg_cl | input | 3 | CAS latency, 3 to 5 |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| bank_open | input | 8 | One open flag per bank |
| req_valid | input | 1 | Read request present |
| req_bank | input | 3 | Requested bank |
| req_col | input | COL_W | Requested column |
| req_tag | input | TAG_W | Tag carried to the data window |
| req_ready | output | 1 | Request can be accepted this cycle |
| cmd_code | output | 3 | Command code: READ 3'b101, NOP 3'b111 |
| cmd_bank | output | 3 | Bank of the READ |
| cmd_col | output | COL_W | Column of the READ |
| rd_err | output | 1 | Pulse for a request to a closed bank |
| dv_valid | output | 1 | Read data is due this cycle |
| dv_tag | output | TAG_W | Tag of the burst in flight |
| dv_pair | output | 2 | Beat-pair index within the burst |

## Verification
Two things can happen in the same clock. A rejection pulse for a closed bank can coincide with a data beat of an earlier burst. A new READ command can coincide with the data window of the burst before it. The bench provokes both: in every latency and burst-length setting, it sends a closed-bank request right after a seamless pair of reads, followed at once by another open read. It predicts every output per cycle from the acceptance edges alone and checks that the error, the command, the ready flag and the data window are each correct in those shared cycles, with no lost or shifted beat.

// File: rtl/ddr2_rd_pkg.sv
package ddr2_rd_pkg;

    // Command encodings on {RAS#, CAS#, WE#}
    typedef enum logic [2:0] {
        CMD_READ = 3'b101,
        CMD_NOP  = 3'b111
    } cmd_e;

    localparam int MAX_AL    = 4;
    localparam int MIN_CL    = 3;
    localparam int MAX_CL    = 5;
    localparam int MAX_PAIRS = 4;

    function automatic int pairs_of(input logic bl8);
        return bl8 ? 4 : 2;
    endfunction

endpackage

// File: rtl/rd_spacing.sv
module rd_spacing (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic bl8_i,
    output logic ready_o
);
    typedef struct packed {
        logic [1:0] gap;
    } sp_st_t;

    sp_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (issue_i) begin
            s_d.gap = bl8_i ? 2'd3 : 2'd1;
        end else if (s_q.gap != 2'd0) begin
            s_d.gap = s_q.gap - 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready_o = (s_q.gap == 2'd0);

    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> !ready_o); // R6
    AST_GAP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !bl8_i) |=> ##1 ready_o); // R6

endmodule

// File: rtl/rd_cmd_gate.sv
module rd_cmd_gate
    import ddr2_rd_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int COL_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept_i,
    input  logic [BANK_W-1:0]        bank_i,
    input  logic [COL_W-1:0]         col_i,
    input  logic [(1<<BANK_W)-1:0]   bank_open_i,
    output logic                     issue_o,
    output cmd_e                     cmd_o,
    output logic [BANK_W-1:0]        cmd_bank_o,
    output logic [COL_W-1:0]         cmd_col_o,
    output logic                     err_o
);
    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              err;
    } gate_st_t;

    gate_st_t s_d, s_q;
    logic     is_open;

    always_comb begin
        is_open = bank_open_i[bank_i];
        issue_o = accept_i && is_open;
        s_d     = s_q;
        s_d.cmd = issue_o ? CMD_READ : CMD_NOP;
        s_d.err = accept_i && !is_open;
        if (issue_o) begin
            s_d.bank = bank_i;
            s_d.col  = col_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cmd  <= CMD_NOP;
            s_q.bank <= '0;
            s_q.col  <= '0;
            s_q.err  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_o      = s_q.cmd;
    assign cmd_bank_o = s_q.bank;
    assign cmd_col_o  = s_q.col;
    assign err_o      = s_q.err;

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (cmd_o == CMD_NOP)); // R3
    AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !bank_open_i[bank_i]) |=> (err_o && cmd_o == CMD_NOP)); // R3

endmodule

// File: rtl/rd_return_pipe.sv
module rd_return_pipe
    import ddr2_rd_pkg::*;
#(
    parameter int TAG_W = 4,
    parameter int DEPTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [2:0]       al_i,
    input  logic [2:0]       cl_i,
    input  logic             bl8_i,
    output logic             dv_o,
    output logic [TAG_W-1:0] tag_o,
    output logic [1:0]       pair_o
);
    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [1:0]       pair;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
    } pipe_st_t;

    pipe_st_t s_d, s_q;
    logic     clash;

    always_comb begin
        int rl;
        int npairs;
        int idx;
        rl     = int'(al_i) + int'(cl_i);
        npairs = pairs_of(bl8_i);
        clash  = 1'b0;
        idx    = 0;
        for (int i = 0; i < DEPTH - 1; i++) begin
            s_d.slot[i] = s_q.slot[i+1];
        end
        s_d.slot[DEPTH-1] = '0;
        if (issue_i) begin
            for (int k = 0; k < MAX_PAIRS; k++) begin
                idx = rl + k;
                if (k < npairs && idx < DEPTH) begin
                    clash = clash | s_d.slot[idx].vld;
                    s_d.slot[idx].vld  = 1'b1;
                    s_d.slot[idx].tag  = tag_i;
                    s_d.slot[idx].pair = 2'(k);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dv_o   = s_q.slot[0].vld;
    assign tag_o  = s_q.slot[0].tag;
    assign pair_o = s_q.slot[0].pair;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> !clash); // R6
    AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_o && pair_o != 2'd0) |-> ($past(dv_o) && pair_o == $past(pair_o) + 2'd1)); // R5
    AST_PAIR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_o && $past(dv_o) && pair_o == 2'd0) |-> ($past(pair_o) == (bl8_i ? 2'd3 : 2'd1))); // R7

endmodule

// File: rtl/ddr2_rd_sched.sv
module ddr2_rd_sched
    import ddr2_rd_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int COL_W  = 10,
    parameter int TAG_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             cfg_al,
    input  logic [2:0]             cfg_cl,
    input  logic                   cfg_bl8,
    input  logic [(1<<BANK_W)-1:0] bank_open,
    input  logic                   req_valid,
    input  logic [BANK_W-1:0]      req_bank,
    input  logic [COL_W-1:0]       req_col,
    input  logic [TAG_W-1:0]       req_tag,
    output logic                   req_ready,
    output logic [2:0]             cmd_code,
    output logic [BANK_W-1:0]      cmd_bank,
    output logic [COL_W-1:0]       cmd_col,
    output logic                   rd_err,
    output logic                   dv_valid,
    output logic [TAG_W-1:0]       dv_tag,
    output logic [1:0]             dv_pair
);
    localparam int DEPTH = MAX_AL + MAX_CL + MAX_PAIRS + 1;

    logic accept;
    logic issue;
    cmd_e cmd;

    assign accept   = req_valid && req_ready;
    assign cmd_code = cmd;

    rd_spacing u_spacing (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i (issue),
        .bl8_i   (cfg_bl8),
        .ready_o (req_ready)
    );

    rd_cmd_gate #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .bank_i      (req_bank),
        .col_i       (req_col),
        .bank_open_i (bank_open),
        .issue_o     (issue),
        .cmd_o       (cmd),
        .cmd_bank_o  (cmd_bank),
        .cmd_col_o   (cmd_col),
        .err_o       (rd_err)
    );

    rd_return_pipe #(
        .TAG_W (TAG_W),
        .DEPTH (DEPTH)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i (issue),
        .tag_i   (req_tag),
        .al_i    (cfg_al),
        .cl_i    (cfg_cl),
        .bl8_i   (cfg_bl8),
        .dv_o    (dv_valid),
        .tag_o   (dv_tag),
        .pair_o  (dv_pair)
    );

    AST_READ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_READ) |-> $past(req_valid && req_ready)); // R2
    AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (int'(cfg_al) <= MAX_AL && int'(cfg_cl) >= MIN_CL && int'(cfg_cl) <= MAX_CL)); // R8
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == CMD_READ) |=> (cmd_code == CMD_NOP)); // R2

endmodule

// File: tb/ddr2_rd_sched_tb_top.sv
module ddr2_rd_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 10;
    localparam int TAG_W      = 4;
    localparam int RING       = 64;
    localparam int WDOG       = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cfg_al = 3'd0;
    logic [2:0]       cfg_cl = 3'd3;
    logic             cfg_bl8 = 1'b0;
    logic [7:0]       bank_open = 8'h00;
    logic             req_valid = 1'b0;
    logic [2:0]       req_bank = 3'd0;
    logic [COL_W-1:0] req_col = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic             req_ready;
    logic [2:0]       cmd_code;
    logic [2:0]       cmd_bank;
    logic [COL_W-1:0] cmd_col;
    logic             rd_err;
    logic             dv_valid;
    logic [TAG_W-1:0] dv_tag;
    logic [1:0]       dv_pair;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 1'b0;

    bit e_cmd  [RING];
    int e_bank [RING];
    int e_col  [RING];
    bit e_err  [RING];
    bit e_busy [RING];
    bit e_dv   [RING];
    int e_tag  [RING];
    int e_pair [RING];

    ddr2_rd_sched #(.BANK_W(3), .COL_W(COL_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
        .bank_open(bank_open), .req_valid(req_valid), .req_bank(req_bank),
        .req_col(req_col), .req_tag(req_tag), .req_ready(req_ready),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .rd_err(rd_err),
        .dv_valid(dv_valid), .dv_tag(dv_tag), .dv_pair(dv_pair)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    // Per-cycle comparison against the predicted ring
    always @(negedge clk) begin
        int ix;
        if (mon_on) begin
            ix = cyc % RING;
            chk("R2 R9", "cmd_code", int'(cmd_code), e_cmd[ix] ? 5 : 7);
            if (e_cmd[ix]) begin
                chk("R2", "cmd_bank", int'(cmd_bank), e_bank[ix]);
                chk("R2", "cmd_col", int'(cmd_col), e_col[ix]);
            end
            chk("R3", "rd_err", int'(rd_err), int'(e_err[ix]));
            chk("R6 R3", "req_ready", int'(req_ready), int'(!e_busy[ix]));
            chk("R4 R7 R8", "dv_valid", int'(dv_valid), int'(e_dv[ix]));
            if (e_dv[ix]) begin
                chk("R5 R7", "dv_tag", int'(dv_tag), e_tag[ix]);
                chk("R5 R7", "dv_pair", int'(dv_pair), e_pair[ix]);
            end
            e_cmd[ix] = 0; e_err[ix] = 0; e_busy[ix] = 0; e_dv[ix] = 0;
        end
    end

    // Present one request at a negedge, wait for ready, record predictions
    task automatic send(input int b, input int col, input int tag);
        int a;
        int rl;
        int np;
        req_valid = 1'b1;
        req_bank  = 3'(b);
        req_col   = COL_W'(col);
        req_tag   = TAG_W'(tag);
        while (!req_ready) @(negedge clk);
        a  = cyc + 1;
        rl = int'(cfg_al) + int'(cfg_cl);
        np = cfg_bl8 ? 4 : 2;
        if (bank_open[b]) begin
            e_cmd[a % RING]  = 1;
            e_bank[a % RING] = b;
            e_col[a % RING]  = col;
            for (int j = 0; j < np - 1; j++) e_busy[(a + j) % RING] = 1;
            for (int k = 0; k < np; k++) begin
                e_dv[(a + rl + k) % RING]   = 1;
                e_tag[(a + rl + k) % RING]  = tag;
                e_pair[(a + rl + k) % RING] = k;
            end
        end else begin
            e_err[a % RING] = 1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual %0d expected below %0d cycles", cyc, WDOG);
        summary();
        $finish;
    end

    initial begin
        int tag;
        int o1;
        int o2;
        int cb;
        tag = 0;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1", "cmd_code in reset", int'(cmd_code), 7);
        chk("R1", "dv_valid in reset", int'(dv_valid), 0);
        chk("R1", "rd_err in reset", int'(rd_err), 0);
        chk("R1", "req_ready in reset", int'(req_ready), 1);
        rst_n  = 1'b1;
        mon_on = 1'b1;
        for (int bl = 0; bl < 2; bl++) begin
            for (int al = 0; al <= 4; al++) begin
                for (int cl = 3; cl <= 5; cl++) begin
                    repeat (16) @(negedge clk);   // drain: nothing outstanding (R8)
                    cfg_bl8 = bl[0];
                    cfg_al  = 3'(al);
                    cfg_cl  = 3'(cl);
                    o1 = (al * 2 + cl) % 8;
                    o2 = (o1 + 3) % 8;
                    cb = (o1 + 1) % 8;
                    bank_open = 8'((1 << o1) | (1 << o2));
                    // R9 same bank seamless, R3 rejection, then different bank seamless
                    send(o1, al * 16 + cl, tag); tag = (tag + 1) % 16;
                    send(o1, al * 16 + cl + 1, tag); tag = (tag + 1) % 16;
                    send(cb, 5, tag); tag = (tag + 1) % 16;
                    send(o2, 700 + al, tag); tag = (tag + 1) % 16;
                    send(o1, 900 + cl, tag); tag = (tag + 1) % 16;
                end
            end
        end
        repeat (20) @(negedge clk);
        summary();
        $finish;
    end

endmodule